// File: doc/BRIEF.md
# Diagnostic Node Selector with Divider Bypass

This block picks one of eight internal nodes of a clock synthesizer and presents it on a single diagnostic output, under control of a 3-bit test code. The candidates are a captured serial-stream bit, two constant levels, the reference clock halved, the feedback counter output, the synthesized output clock, and that output clock divided by four. One code also asks the surrounding dividers to take their clock from the serial programming clock rather than from the synthesizer. A bypass flag tells them so, and the feedback counter output is shown on the test pin while that mode is active.

All clock-like inputs are treated as level signals sampled by the block clock `clk`. Rising edges are found by comparing each input with its value at the previous sample. The frequency dividers and the serial-bit capture advance only on those detected edges. The selection itself is combinational, so a new code takes effect in the same cycle it is applied. The divider ratios are parameters checked during elaboration.

Top module: `diag_node_select`

## Requirements
- R1: After reset the reference halver, the output-clock quarterer and the serial-bit capture all hold 0. Code 000, 010 or 111 then shows 0 on `test_o`.
- R2: Code 000 shows the value of `ser_bit_i` sampled at the most recent detected rising edge of `ser_clk_i`. Between such edges the output holds its value.
- R3: Code 001 drives `test_o` high and code 101 drives it low. No other input has any effect on `test_o` under these codes.
- R4: Code 010 shows the reference halver. Its state inverts once on each detected rising edge of `ref_clk_i`.
- R5: Code 011 passes `fb_cnt_i` to `test_o` in the same cycle.
- R6: Code 100 passes `out_clk_i` to `test_o` in the same cycle.
- R7: Code 111 shows the quarterer. This is a 2-bit count of detected rising edges of `out_clk_i`, and its upper bit is the output, so the output inverts on every second edge.
- R8: `bypass_o` is 1 only for code 110, and is 0 for every other code. While it is 1, `test_o` equals `fb_cnt_i`.
- R9: A code change alters `test_o` in the same cycle. The divider and capture states keep running whatever code is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_code_i | input | 3 | Diagnostic node select code |
| ref_clk_i | input | 1 | Reference clock, sampled as a level |
| ser_clk_i | input | 1 | Serial programming clock, sampled as a level |
| ser_bit_i | input | 1 | Serial output bit of the programming shift register |
| fb_cnt_i | input | 1 | Feedback counter output |
| out_clk_i | input | 1 | Synthesized output clock, sampled as a level |
| test_o | output | 1 | Selected diagnostic node |
| bypass_o | output | 1 | Tells the dividers to use the serial clock |

## Verification
The assertions take every input to be synchronous to `clk`. They also take an input edge to be visible only when the input holds each level for at least one sample, and all inputs to be low while reset is asserted. The stimulus meets these conditions. It changes inputs only on the falling edge of `clk` and keeps every clock-like input at one level for at least one full cycle. It also holds everything low during reset. It changes the code in mid-run so that the held-state properties see both settled and freshly switched selections.

// File: rtl/diag_pkg.sv
package diag_pkg;

   typedef enum logic [2:0] {
      SEL_SER_BIT  = 3'b000,
      SEL_ONE      = 3'b001,
      SEL_REF_HALF = 3'b010,
      SEL_FB_CNT   = 3'b011,
      SEL_OUT_CLK  = 3'b100,
      SEL_ZERO     = 3'b101,
      SEL_BYPASS   = 3'b110,
      SEL_OUT_QTR  = 3'b111
   } test_sel_e;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned MAX_DIV_LOG2 = 8;

endpackage

// File: rtl/diag_edge_div.sv
module diag_edge_div #(
   parameter int unsigned DIV_LOG2 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic div_o
);

   logic lvl_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise = lvl_i & ~lvl_q;

   generate
      if (DIV_LOG2 == 1) begin : g_toggle
         logic tog_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    tog_q <= 1'b0;
            else if (rise) tog_q <= ~tog_q;
         end
         assign div_o = tog_q;
      end else begin : g_count
         localparam int unsigned CW = DIV_LOG2;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (rise) cnt_q <= cnt_q + 1'b1;
         end
         assign div_o = cnt_q[CW-1];
      end
   endgenerate

endmodule

// File: rtl/diag_ser_capture.sv
module diag_ser_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic bit_i,
   output logic cap_o
);

   logic sclk_q;
   logic cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cap_q  <= 1'b0;
      end else begin
         sclk_q <= sclk_i;
         if (sclk_i && !sclk_q) cap_q <= bit_i;
      end
   end

   assign cap_o = cap_q;

endmodule

// File: rtl/diag_node_mux.sv
module diag_node_mux
   import diag_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   input  logic              cap_i,
   input  logic              ref_half_i,
   input  logic              fb_i,
   input  logic              out_clk_i,
   input  logic              out_qtr_i,
   output logic              node_o,
   output logic              bypass_o
);

   test_sel_e sel;
   assign sel = test_sel_e'(code_i);

   always_comb begin
      node_o   = 1'b0;
      bypass_o = 1'b0;
      unique case (sel)
         SEL_SER_BIT:  node_o = cap_i;
         SEL_ONE:      node_o = 1'b1;
         SEL_REF_HALF: node_o = ref_half_i;
         SEL_FB_CNT:   node_o = fb_i;
         SEL_OUT_CLK:  node_o = out_clk_i;
         SEL_ZERO:     node_o = 1'b0;
         SEL_BYPASS: begin
            node_o   = fb_i;
            bypass_o = 1'b1;
         end
         SEL_OUT_QTR:  node_o = out_qtr_i;
         default:      node_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/diag_node_select.sv
module diag_node_select
   import diag_pkg::*;
#(
   parameter int unsigned REF_DIV_LOG2 = 1,
   parameter int unsigned OUT_DIV_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] test_code_i,
   input  logic       ref_clk_i,
   input  logic       ser_clk_i,
   input  logic       ser_bit_i,
   input  logic       fb_cnt_i,
   input  logic       out_clk_i,
   output logic       test_o,
   output logic       bypass_o
);

   generate
      if (REF_DIV_LOG2 < 1 || REF_DIV_LOG2 > MAX_DIV_LOG2) begin : g_bad_ref
         $error("REF_DIV_LOG2 out of range");
      end
      if (OUT_DIV_LOG2 < 1 || OUT_DIV_LOG2 > MAX_DIV_LOG2) begin : g_bad_out
         $error("OUT_DIV_LOG2 out of range");
      end
   endgenerate

   logic cap;
   logic ref_half;
   logic out_qtr;

   diag_ser_capture u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (ser_clk_i),
      .bit_i  (ser_bit_i),
      .cap_o  (cap)
   );

   diag_edge_div #(.DIV_LOG2(REF_DIV_LOG2)) u_ref_div (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (ref_clk_i),
      .div_o (ref_half)
   );

   diag_edge_div #(.DIV_LOG2(OUT_DIV_LOG2)) u_out_div (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (out_clk_i),
      .div_o (out_qtr)
   );

   diag_node_mux u_mux (
      .code_i     (test_code_i),
      .cap_i      (cap),
      .ref_half_i (ref_half),
      .fb_i       (fb_cnt_i),
      .out_clk_i  (out_clk_i),
      .out_qtr_i  (out_qtr),
      .node_o     (test_o),
      .bypass_o   (bypass_o)
   );

endmodule

// File: rtl/diag_node_select_chk.sv
module diag_node_select_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] test_code_i,
   input logic       ref_clk_i,
   input logic       ser_clk_i,
   input logic       fb_cnt_i,
   input logic       out_clk_i,
   input logic       test_o,
   input logic       bypass_o
);

   assert_ser_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b000 && $past(test_code_i) == 3'b000 && !$past($rose(ser_clk_i)))
      |-> $stable(test_o));

   assert_const_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b001) |-> test_o);

   assert_const_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b101) |-> !test_o);

   assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b010 && $past(test_code_i) == 3'b010 && !$past($rose(ref_clk_i)))
      |-> $stable(test_o));

   assert_ref_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b010 && $past(test_code_i) == 3'b010 && $past($rose(ref_clk_i)))
      |-> (test_o != $past(test_o)));

   assert_fb_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b011) |-> (test_o == fb_cnt_i));

   assert_out_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_code_i == 3'b100) |-> (test_o == out_clk_i));

   assert_bypass_node_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_o |-> (test_o == fb_cnt_i && test_code_i == 3'b110));

endmodule

bind diag_node_select diag_node_select_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_code_i (test_code_i),
   .ref_clk_i   (ref_clk_i),
   .ser_clk_i   (ser_clk_i),
   .fb_cnt_i    (fb_cnt_i),
   .out_clk_i   (out_clk_i),
   .test_o      (test_o),
   .bypass_o    (bypass_o)
);

// File: tb/diag_node_select_tb_top.sv
`timescale 1ns/1ps
module diag_node_select_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] code = 3'b000;
   logic       ref_c = 1'b0;
   logic       sclk = 1'b0;
   logic       sbit = 1'b0;
   logic       fb = 1'b0;
   logic       oclk = 1'b0;
   logic       test_o;
   logic       bypass_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int tick = 0;

   always #2 clk = ~clk;

   diag_node_select dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_code_i (code),
      .ref_clk_i   (ref_c),
      .ser_clk_i   (sclk),
      .ser_bit_i   (sbit),
      .fb_cnt_i    (fb),
      .out_clk_i   (oclk),
      .test_o      (test_o),
      .bypass_o    (bypass_o)
   );

   // behavioural reference: edge counts and last captured serial bit
   int  m_ref_rises, m_out_rises;
   bit  m_cap, m_ref_p, m_sclk_p, m_out_p;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ref_rises <= 0; m_out_rises <= 0; m_cap <= 0;
         m_ref_p <= 0; m_sclk_p <= 0; m_out_p <= 0;
      end else begin
         if (ref_c && !m_ref_p) m_ref_rises <= m_ref_rises + 1;
         if (oclk && !m_out_p)  m_out_rises <= m_out_rises + 1;
         if (sclk && !m_sclk_p) m_cap <= sbit;
         m_ref_p <= ref_c; m_sclk_p <= sclk; m_out_p <= oclk;
      end
   end

   function automatic bit exp_node();
      case (code)
         3'b000: return m_cap;
         3'b001: return 1'b1;
         3'b010: return m_ref_rises[0];
         3'b011: return fb;
         3'b100: return oclk;
         3'b101: return 1'b0;
         3'b110: return fb;
         default: return m_out_rises[1];
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] c);
      case (c)
         3'b000: return "R2";
         3'b001, 3'b101: return "R3";
         3'b010: return "R4";
         3'b011: return "R5";
         3'b100: return "R6";
         3'b110: return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s code=%b actual=%b expected=%b time=%0t", req, code, act, exp, $time);
      end
   endtask

   task automatic drive_next();
      tick++;
      if (tick % 3 == 0) ref_c = ~ref_c;
      if (tick % 2 == 0) oclk = ~oclk;
      if (tick % 5 == 0) sclk = ~sclk;
      sbit = 1'($urandom_range(0, 1));
      fb   = 1'($urandom_range(0, 1));
   endtask

   task automatic run_code(logic [2:0] c, int n);
      code = c;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) check("R9", test_o, exp_node());
         else        check(tag_of(c), test_o, exp_node());
         check("R8", bypass_o, (c == 3'b110));
         drive_next();
      end
   endtask

   initial begin
      void'($urandom(17));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      code = 3'b010; #0.1 check("R1", test_o, 1'b0);
      code = 3'b111; #0.1 check("R1", test_o, 1'b0);
      code = 3'b000; #0.1 check("R1", test_o, 1'b0);
      check("R1", bypass_o, 1'b0);
      for (int pass = 0; pass < 3; pass++) begin
         run_code(3'b000, 40);
         run_code(3'b001, 20);
         run_code(3'b010, 40);
         run_code(3'b011, 20);
         run_code(3'b100, 20);
         run_code(3'b101, 20);
         run_code(3'b110, 30);
         run_code(3'b111, 40);
      end
      // rapid code switching: dividers keep counting while unselected
      for (int k = 0; k < 64; k++) run_code(3'(k % 8), 3);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule